// File: doc/BRIEF.md
# Instruction Fetch Address Checker

This block screens every 4-byte instruction fetch address before it reaches the fetch path. On each cycle where the fetch strobe is high it clears the two low address bits and classifies the address against a set of protected windows in the upper address space. It reports the result as three flags: misaligned, fetch access error and fetch access exception.

A two-bit select chooses one of three core variants. Each variant has its own window layout and handles misalignment in its own way. One low window per variant can be opened by a region-enable input, and while it is open, fetches there are allowed. Error windows always win over exception windows, so at most one of those two flags is raised for a fetch. Every result is registered and appears one cycle after the strobe.

Top module: `fetch_addr_guard`

## Requirements
- R1: The result of a fetch presented with `fetchValid` high at a clock edge appears on the outputs after that edge, with `outValid` high, and stays there until the next edge.
- R2: `outAddr` equals the fetch address with bits [1:0] forced to zero, for every variant code.
- R3: Variant A (`variantSel` = 2'b00): a fetch address with either of bits [1:0] set raises `accessErr` and never `misalignFlag`.
- R4: Variant A: an aligned address in 0xFE800000..0xFEFFFFFF raises `accessErr`. Variant A never raises `accessExc`.
- R5: Variant B (`variantSel` = 2'b01): a fetch address with either of bits [1:0] set raises `misalignFlag`, and the window checks use the aligned address.
- R6: Variant B: aligned addresses in 0xFE800000..0xFEFEFFFF or 0xFEFF0600..0xFEFF7FFF raise `accessErr`. The gaps 0xFEFF0000..0xFEFF05FF and 0xFEFF8000..0xFEFFFFFF raise nothing.
- R7: Variant B: an aligned address in 0xFE004000..0xFE7FFFFF raises `accessExc`.
- R8: Variant B: an aligned address in 0xFE000000..0xFE003FFF raises `accessExc` only while `regionEn` is 0.
- R9: Variant C (`variantSel` = 2'b10) aligns without any flag. An aligned address in 0xFE800000..0xFEFFFFFF raises `accessErr`.
- R10: Variant C: 0xFE008000..0xFE7FFFFF raises `accessExc`. 0xFE000000..0xFE007FFF raises `accessExc` only while `regionEn` is 0.
- R11: `accessErr` and `accessExc` are never high together.
- R12: An address outside every window of the selected variant raises no flag. With `variantSel` = 2'b11, no address raises any flag.
- R13: After reset, and in the cycle after an edge with `fetchValid` low, `outValid` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch address strobe |
| fetchAddr | input | 32 | Fetch byte address |
| variantSel | input | 2 | Core variant: 00 A, 01 B, 10 C, 11 no checks |
| regionEn | input | 1 | Opens the low gated window when 1 |
| outValid | output | 1 | Registered result valid |
| outAddr | output | 32 | Aligned fetch address |
| misalignFlag | output | 1 | Misaligned fetch (variant B only) |
| accessErr | output | 1 | Fetch access error |
| accessExc | output | 1 | Fetch access exception |

## Verification
The hardest cases sit where windows meet. A misaligned address whose raw value lies just inside a window while its aligned value lies outside it, or the reverse, shows whether the checks use the aligned address. The gated low window differs between variants B and C, so it has to be probed on both sides of its boundary with `regionEn` at both levels. The stimulus table places addresses at these edges, such as 0xFEFF0601, 0xFEFF05FC and 0xFE004000 under B and under C, and a directed back-to-back run changes the variant on every cycle to expose stale registered results.

// File: rtl/fag_pkg.sv
package fag_pkg;

  typedef enum logic [1:0] {
    VAR_A    = 2'b00,
    VAR_B    = 2'b01,
    VAR_C    = 2'b10,
    VAR_NONE = 2'b11
  } variant_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clear;
  } ctrl_t;

  localparam int NUM_WIN = 7;

  // window indices
  localparam int W_ERR_WIDE = 0;  // FE800000..FEFFFFFF
  localparam int W_ERR_MID  = 1;  // FE800000..FEFEFFFF
  localparam int W_ERR_HOLE = 2;  // FEFF0600..FEFF7FFF
  localparam int W_EXC_B    = 3;  // FE004000..FE7FFFFF
  localparam int W_LOW_B    = 4;  // FE000000..FE003FFF
  localparam int W_EXC_C    = 5;  // FE008000..FE7FFFFF
  localparam int W_LOW_C    = 6;  // FE000000..FE007FFF

  function automatic logic [31:0] winLo(input int idx);
    case (idx)
      W_ERR_WIDE: winLo = 32'hFE80_0000;
      W_ERR_MID:  winLo = 32'hFE80_0000;
      W_ERR_HOLE: winLo = 32'hFEFF_0600;
      W_EXC_B:    winLo = 32'hFE00_4000;
      W_LOW_B:    winLo = 32'hFE00_0000;
      W_EXC_C:    winLo = 32'hFE00_8000;
      default:    winLo = 32'hFE00_0000;
    endcase
  endfunction

  function automatic logic [31:0] winHi(input int idx);
    case (idx)
      W_ERR_WIDE: winHi = 32'hFEFF_FFFF;
      W_ERR_MID:  winHi = 32'hFEFE_FFFF;
      W_ERR_HOLE: winHi = 32'hFEFF_7FFF;
      W_EXC_B:    winHi = 32'hFE7F_FFFF;
      W_LOW_B:    winHi = 32'hFE00_3FFF;
      W_EXC_C:    winHi = 32'hFE7F_FFFF;
      default:    winHi = 32'hFE00_7FFF;
    endcase
  endfunction

endpackage

// File: rtl/fag_window.sv
module fag_window #(
  parameter int              ADDR_W = 32,
  parameter logic [ADDR_W-1:0] LO   = '0,
  parameter logic [ADDR_W-1:0] HI   = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  assign hit = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/fag_ctrl.sv
module fag_ctrl
  import fag_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  fetchValid,
  output ctrl_t strobes,
  output logic  outValid
);
  always_comb begin
    strobes.capture = fetchValid;
    strobes.clear   = ~fetchValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= fetchValid;
  end
endmodule

// File: rtl/fag_datapath.sv
module fag_datapath
  import fag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             strobes,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [1:0]        variantSel,
  input  logic              regionEn,
  output logic [ADDR_W-1:0] outAddr,
  output logic              misalignFlag,
  output logic              accessErr,
  output logic              accessExc
);
  localparam int ALIGN_BITS = $clog2(INSN_BYTES);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(INSN_BYTES - 1);

  logic [ADDR_W-1:0]  alignedAddr;
  logic               rawMis;
  logic [NUM_WIN-1:0] winHit;
  logic               nextMis, nextErr, nextExc;
  variant_e           variant;

  assign alignedAddr = fetchAddr & ~LOW_MASK;
  assign rawMis      = |fetchAddr[ALIGN_BITS-1:0];
  assign variant     = variant_e'(variantSel);

  // one comparator pair per protected window, all on the aligned address
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    fag_window #(
      .ADDR_W(ADDR_W),
      .LO    (ADDR_W'(winLo(g))),
      .HI    (ADDR_W'(winHi(g)))
    ) i_win (
      .addr(alignedAddr),
      .hit (winHit[g])
    );
  end

  // classification: error first, exception only when no error
  always_comb begin
    nextMis = 1'b0;
    nextErr = 1'b0;
    nextExc = 1'b0;
    case (variant)
      VAR_A: begin
        nextErr = rawMis | winHit[W_ERR_WIDE];
      end
      VAR_B: begin
        nextMis = rawMis;
        nextErr = winHit[W_ERR_MID] | winHit[W_ERR_HOLE];
        nextExc = ~nextErr &
                  (winHit[W_EXC_B] | (~regionEn & winHit[W_LOW_B]));
      end
      VAR_C: begin
        nextErr = winHit[W_ERR_WIDE];
        nextExc = ~nextErr &
                  (winHit[W_EXC_C] | (~regionEn & winHit[W_LOW_C]));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outAddr      <= '0;
      misalignFlag <= 1'b0;
      accessErr    <= 1'b0;
      accessExc    <= 1'b0;
    end else if (strobes.capture) begin
      outAddr      <= alignedAddr;
      misalignFlag <= nextMis;
      accessErr    <= nextErr;
      accessExc    <= nextExc;
    end else if (strobes.clear) begin
      misalignFlag <= 1'b0;
      accessErr    <= 1'b0;
      accessExc    <= 1'b0;
    end
  end
endmodule

// File: rtl/fetch_addr_guard.sv
module fetch_addr_guard
  import fag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [1:0]        variantSel,
  input  logic              regionEn,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic              misalignFlag,
  output logic              accessErr,
  output logic              accessExc
);
  ctrl_t strobes;

  fag_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fetchValid(fetchValid),
    .strobes   (strobes),
    .outValid  (outValid)
  );

  fag_datapath #(
    .ADDR_W    (ADDR_W),
    .INSN_BYTES(INSN_BYTES)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .fetchAddr   (fetchAddr),
    .variantSel  (variantSel),
    .regionEn    (regionEn),
    .outAddr     (outAddr),
    .misalignFlag(misalignFlag),
    .accessErr   (accessErr),
    .accessExc   (accessExc)
  );
endmodule

// File: rtl/fag_checker.sv
module fag_checker
  import fag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchValid,
  input logic [1:0]        variantSel,
  input logic              outValid,
  input logic [ADDR_W-1:0] outAddr,
  input logic              misalignFlag,
  input logic              accessErr,
  input logic              accessExc
);
  localparam int ALIGN_BITS = $clog2(INSN_BYTES);

  // R1
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |=> outValid);

  // R13
  idle_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> !outValid && !misalignFlag && !accessErr && !accessExc);

  // R2
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outAddr[ALIGN_BITS-1:0] == '0);

  // R11
  err_exc_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(accessErr && accessExc));

  // R3
  mis_only_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && variantSel != VAR_B |=> !misalignFlag);

  // R4
  a_no_exc_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && variantSel == VAR_A |=> !accessExc);

  // R12
  none_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && variantSel == VAR_NONE |=> !misalignFlag && !accessErr && !accessExc);
endmodule

bind fetch_addr_guard fag_checker #(
  .ADDR_W    (ADDR_W),
  .INSN_BYTES(INSN_BYTES)
) i_fag_checker (
  .clk         (clk),
  .rstN        (rstN),
  .fetchValid  (fetchValid),
  .variantSel  (variantSel),
  .outValid    (outValid),
  .outAddr     (outAddr),
  .misalignFlag(misalignFlag),
  .accessErr   (accessErr),
  .accessExc   (accessExc)
);

// File: tb/test_fetch_addr_guard.sv
module test_fetch_addr_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic [1:0]  variantSel = '0;
  logic        regionEn = 1'b0;
  logic        outValid;
  logic [31:0] outAddr;
  logic        misalignFlag, accessErr, accessExc;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fetch_addr_guard i_fetch_addr_guard (
    .clk         (clk),
    .rstN        (rstN),
    .fetchValid  (fetchValid),
    .fetchAddr   (fetchAddr),
    .variantSel  (variantSel),
    .regionEn    (regionEn),
    .outValid    (outValid),
    .outAddr     (outAddr),
    .misalignFlag(misalignFlag),
    .accessErr   (accessErr),
    .accessExc   (accessExc)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        en;
    logic [31:0] addr;
    logic        mis;
    logic        err;
    logic        exc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 4'd12}, // R12
    '{2'b00, 1'b0, 32'h0000_1002, 1'b0, 1'b1, 1'b0, 4'd3},  // R3
    '{2'b00, 1'b0, 32'h0000_1001, 1'b0, 1'b1, 1'b0, 4'd3},  // R3
    '{2'b00, 1'b0, 32'hFE80_0000, 1'b0, 1'b1, 1'b0, 4'd4},  // R4
    '{2'b00, 1'b0, 32'hFEFF_FFFC, 1'b0, 1'b1, 1'b0, 4'd4},  // R4
    '{2'b00, 1'b0, 32'hFE00_4000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{2'b01, 1'b0, 32'hFEFF_0603, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
    '{2'b01, 1'b0, 32'hFEFF_0601, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
    '{2'b01, 1'b0, 32'h0000_2002, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
    '{2'b01, 1'b0, 32'hFEFF_05FC, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{2'b01, 1'b0, 32'hFEFE_FFFC, 1'b0, 1'b1, 1'b0, 4'd6},  // R6
    '{2'b01, 1'b0, 32'hFEFF_7FFC, 1'b0, 1'b1, 1'b0, 4'd6},  // R6
    '{2'b01, 1'b0, 32'hFEFF_8000, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{2'b01, 1'b1, 32'hFE00_4000, 1'b0, 1'b0, 1'b1, 4'd7},  // R7
    '{2'b01, 1'b0, 32'hFE7F_FFFC, 1'b0, 1'b0, 1'b1, 4'd7},  // R7
    '{2'b01, 1'b0, 32'hFE00_3FFC, 1'b0, 1'b0, 1'b1, 4'd8},  // R8
    '{2'b01, 1'b1, 32'hFE00_3FFC, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{2'b01, 1'b0, 32'hFE00_0002, 1'b1, 1'b0, 1'b1, 4'd8},  // R8
    '{2'b10, 1'b0, 32'hFE80_0003, 1'b0, 1'b1, 1'b0, 4'd9},  // R9
    '{2'b10, 1'b0, 32'hFEFF_FFFC, 1'b0, 1'b1, 1'b0, 4'd9},  // R9
    '{2'b10, 1'b1, 32'hFE00_8000, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
    '{2'b10, 1'b0, 32'hFE00_7FFC, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
    '{2'b10, 1'b1, 32'hFE00_7FFC, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{2'b11, 1'b0, 32'hFE80_0000, 1'b0, 1'b0, 1'b0, 4'd12}, // R12
    '{2'b11, 1'b0, 32'h0000_0003, 1'b0, 1'b0, 1'b0, 4'd12}, // R12
    '{2'b01, 1'b0, 32'hFDFF_FFFC, 1'b0, 1'b0, 1'b0, 4'd12}  // R12
  };

  task automatic check(input int req, input logic v, input logic [31:0] a,
                       input logic m, input logic e, input logic x);
    total++;
    if (outValid !== v || outAddr !== a || misalignFlag !== m ||
        accessErr !== e || accessExc !== x) begin
      bad++;
      $display("FAIL R%0d: got v=%b a=%h m=%b e=%b x=%b exp v=%b a=%h m=%b e=%b x=%b",
               req, outValid, outAddr, misalignFlag, accessErr, accessExc,
               v, a, m, e, x);
    end
  endtask

  task automatic checkIdle(input int req);
    total++;
    if (outValid !== 1'b0 || misalignFlag !== 1'b0 || accessErr !== 1'b0 ||
        accessExc !== 1'b0) begin
      bad++;
      $display("FAIL R%0d: got v=%b m=%b e=%b x=%b exp all 0",
               req, outValid, misalignFlag, accessErr, accessExc);
    end
  endtask

  task automatic drive(input vec_t vv);
    fetchValid = 1'b1;
    variantSel = vv.sel;
    regionEn   = vv.en;
    fetchAddr  = vv.addr;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdle(13); // R13 reset state
    rstN = 1'b1;
    @(negedge clk);
    checkIdle(13); // R13 idle after reset

    // table walk; R2 via aligned expected address on every vector
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check(int'(VECS[i].req), 1'b1, VECS[i].addr & 32'hFFFF_FFFC,
            VECS[i].mis, VECS[i].err, VECS[i].exc);
    end

    // R13: strobe drops, flags clear next cycle
    fetchValid = 1'b0;
    fetchAddr  = 32'hFE80_0000;
    @(negedge clk);
    checkIdle(13);

    // R1: back-to-back, variant changes each cycle
    drive(VECS[7]);             // B FEFF0601
    @(negedge clk);
    check(1, 1'b1, 32'hFEFF_0600, 1'b1, 1'b1, 1'b0);
    drive(VECS[21]);            // C FE007FFC en=0
    @(negedge clk);
    check(1, 1'b1, 32'hFE00_7FFC, 1'b0, 1'b0, 1'b1);
    drive(VECS[1]);             // A misaligned
    @(negedge clk);
    check(1, 1'b1, 32'h0000_1000, 1'b0, 1'b1, 1'b0);
    // same address under B and C differs only by window layout (R7, R10)
    fetchAddr = 32'hFE00_4000; variantSel = 2'b01; regionEn = 1'b1;
    @(negedge clk);
    check(7, 1'b1, 32'hFE00_4000, 1'b0, 1'b0, 1'b1);
    variantSel = 2'b10;
    @(negedge clk);
    check(10, 1'b1, 32'hFE00_4000, 1'b0, 1'b0, 1'b0);
    // R11 spot check: error window wins
    variantSel = 2'b01; fetchAddr = 32'hFE80_0000; regionEn = 1'b0;
    @(negedge clk);
    check(11, 1'b1, 32'hFE80_0000, 1'b0, 1'b1, 1'b0);
    fetchValid = 1'b0;
    @(negedge clk);
    checkIdle(13);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule